// File: doc/BRIEF.md
# Energy and RMS Computation Engine

This block turns a stream of signed 24-bit voltage and current samples into metering results. Each conversion strobe delivers one voltage/current pair. Each sample is first corrected by adding a signed offset and then scaling by an unsigned gain. The two corrected samples are multiplied to give an instantaneous power sample. Over a window of N conversions, with N taken from a cycle-count input, the engine sums the power samples and the squares of each corrected sample.

When a window closes, the block does three things. It scales the power sum down by 4096 to form an energy result. It divides each sum of squares by N with a serial divider. It then takes the square root of each mean with a bit-serial digit-by-digit root, which gives the RMS voltage and RMS current.

Two sticky status flags report progress. One flags a finished conversion and the other a finished window. Both drive one interrupt output through per-flag masks. A run is either a single window or continuous windows, and it stops on halt, on soft reset or on hardware reset.

Top module: `pwr_meas_engine`

## Requirements
- R1: A corrected sample is floor((sample + offset) * gain / 2^22), saturated to the range -(2^23-1) to 2^23-1. The gain is unsigned, with 0x400000 meaning 1.0. The corrected voltage and current appear on `inst_v` and `inst_i` one clock edge after an accepted strobe. The code 0x800000 is never output.
- R2: `inst_p` equals floor(inst_v * inst_i / 2^23) as a 24-bit two's complement value. It updates two clock edges after an accepted strobe.
- R3: At the end of each window of N accepted conversions, `energy` becomes the sum of the window's N power samples, arithmetically shifted right by 12 and saturated to ±(2^23-1). A `cycle_cnt` of 0 acts as 1.
- R4: `v_rms` and `i_rms` are unsigned 24-bit fractions of full scale, each equal to floor(sqrt(4 * floor(S / N))), where S is the window's sum of squared corrected samples. They are published on the same edge as `energy`.
- R5: `crdy` sets after every accepted conversion. `drdy` sets only once a window's results are published, so with N = 1 every conversion also raises `drdy`, and `drdy` stays low while a window is still open.
- R6: Both flags are sticky and stay set until a pulse on `clr_crdy` or `clr_drdy` clears them.
- R7: `irq` is high exactly when (`crdy` and `mask_crdy`) or (`drdy` and `mask_drdy`).
- R8: With `cont_mode` low at `start`, one window runs and the engine goes idle. Strobes while idle change neither `inst_v`, `inst_i`, `inst_p` nor `crdy`.
- R9: With `cont_mode` high at `start`, windows repeat back to back until `halt`, after which strobes are ignored and no further `drdy` occurs.
- R10: `rms_ok` is 0 for the first window of every run and for any window with N ≤ 10. It is 1 otherwise. Energy is valid from the first window.
- R11: Hardware reset and `soft_rst` clear all sample outputs, results, flags and the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all state |
| start | input | 1 | Begin a run (pulse) |
| cont_mode | input | 1 | Sampled at start: 1 continuous, 0 single window |
| halt | input | 1 | Stop a run (pulse) |
| conv_stb | input | 1 | A new sample pair is present |
| v_smp | input | 24 | Voltage sample, two's complement |
| i_smp | input | 24 | Current sample, two's complement |
| v_off | input | 24 | Voltage offset, two's complement |
| i_off | input | 24 | Current offset, two's complement |
| v_gain | input | 24 | Voltage gain, unsigned, 0x400000 = 1.0 |
| i_gain | input | 24 | Current gain, unsigned, 0x400000 = 1.0 |
| cycle_cnt | input | 24 | Conversions per window (N) |
| clr_crdy | input | 1 | Clear conversion-ready flag |
| clr_drdy | input | 1 | Clear cycle-ready flag |
| mask_crdy | input | 1 | Let conversion-ready drive the interrupt |
| mask_drdy | input | 1 | Let cycle-ready drive the interrupt |
| inst_v | output | 24 | Corrected voltage sample |
| inst_i | output | 24 | Corrected current sample |
| inst_p | output | 24 | Instantaneous power |
| energy | output | 24 | Window energy result |
| v_rms | output | 24 | RMS voltage, unsigned fraction |
| i_rms | output | 24 | RMS current, unsigned fraction |
| rms_ok | output | 1 | RMS results of the last window are valid |
| crdy | output | 1 | Sticky conversion-ready flag |
| drdy | output | 1 | Sticky cycle-ready flag |
| irq | output | 1 | Masked interrupt |

## Verification
The corrected samples are due one rising edge after the strobe and the power sample two edges after it. The bench drives inputs on falling edges and reads `inst_v`/`inst_i` one falling edge after the strobe and `inst_p` one edge later. Window results arrive only after the divide (one step per sum-of-squares bit) and the root (one step per result bit), roughly 95 cycles at default widths. The bench therefore polls `drdy` at falling edges with a bounded wait and reads `energy`, the RMS outputs and `rms_ok` in the cycle it sees the flag. Absence checks (idle strobes, halted runs, an open window) hold a fixed wait longer than that latency before reading the outputs.

// File: rtl/pme_pkg.sv
package pme_pkg;
   typedef enum logic [1:0] {
      RUN_IDLE = 2'd0,
      RUN_ONCE = 2'd1,
      RUN_LOOP = 2'd2
   } run_e;
endpackage

// File: rtl/pme_adjust.sv
module pme_adjust #(
   parameter int SW = 24,
   parameter int GW = 24,
   parameter int GF = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_clr,
   input  logic                 en,
   input  logic signed [SW-1:0] smp,
   input  logic signed [SW-1:0] off,
   input  logic [GW-1:0]        gain,
   output logic signed [SW-1:0] adj
);
   localparam int PW = SW + GW + 2;
   localparam logic signed [PW-1:0] MAXV = $signed({{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}});
   localparam logic signed [PW-1:0] MINV = -MAXV;

   generate
      if (GF >= GW || SW < 8) begin : g_bad_cfg
         $error("pme_adjust: gain fraction or sample width out of range");
      end
   endgenerate

   logic signed [SW:0]   sum_c;
   logic signed [PW-1:0] prod_c;
   logic signed [PW-1:0] shv_c;

   always_comb begin
      sum_c  = {smp[SW-1], smp} + {off[SW-1], off};
      prod_c = PW'(sum_c) * PW'($signed({1'b0, gain}));
      shv_c  = prod_c >>> GF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj <= '0;
      end else if (soft_clr) begin
         adj <= '0;
      end else if (en) begin
         if (shv_c > MAXV)      adj <= SW'(MAXV);
         else if (shv_c < MINV) adj <= SW'(MINV);
         else                   adj <= SW'(shv_c);
      end
   end

   // R1: the most negative code never leaves the saturation stage
   a_r1_no_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (adj != {1'b1, {(SW-1){1'b0}}}));
endmodule

// File: rtl/pme_serial_div.sv
module pme_serial_div #(
   parameter int DW = 70,
   parameter int VW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_clr,
   input  logic          start,
   input  logic [DW-1:0] dividend,
   input  logic [VW-1:0] divisor,
   output logic          done,
   output logic [DW-1:0] quo
);
   localparam int CNTW = $clog2(DW + 1);

   generate
      if (VW < 1 || DW < VW) begin : g_bad_cfg
         $error("pme_serial_div: widths out of range");
      end
   endgenerate

   logic [VW-1:0]   rem_q;
   logic [VW-1:0]   dvs_q;
   logic [CNTW-1:0] cnt_q;
   logic            busy_q;
   logic [VW:0]     sh_c;
   logic [VW:0]     dif_c;
   logic            fit_c;

   always_comb begin
      sh_c  = {rem_q, quo[DW-1]};
      dif_c = sh_c - {1'b0, dvs_q};
      fit_c = (sh_c >= {1'b0, dvs_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0; dvs_q <= '0; cnt_q <= '0; busy_q <= 1'b0; done <= 1'b0; quo <= '0;
      end else if (soft_clr) begin
         rem_q <= '0; dvs_q <= '0; cnt_q <= '0; busy_q <= 1'b0; done <= 1'b0; quo <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            quo    <= dividend;
            dvs_q  <= divisor;
            rem_q  <= '0;
            cnt_q  <= CNTW'(DW);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            rem_q <= fit_c ? VW'(dif_c) : VW'(sh_c);
            quo   <= {quo[DW-2:0], fit_c};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNTW'(1)) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   // R4: completion is a single-cycle strobe
   a_r4_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/pme_sqrt.sv
module pme_sqrt #(
   parameter int SW = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_clr,
   input  logic            start,
   input  logic [2*SW-1:0] rad,
   output logic            done,
   output logic [SW-1:0]   root
);
   localparam int RW   = 2 * SW;
   localparam int CNTW = $clog2(SW + 1);

   logic [RW-1:0]   rad_q;
   logic [RW-1:0]   chk_q;
   logic [SW+1:0]   rem_q;
   logic [CNTW-1:0] cnt_q;
   logic            busy_q;
   logic [SW+1:0]   sh_c;
   logic [SW+1:0]   trial_c;

   always_comb begin
      sh_c    = (rem_q << 2) | {{SW{1'b0}}, rad_q[RW-1:RW-2]};
      trial_c = {root, 2'b01};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rad_q <= '0; chk_q <= '0; rem_q <= '0; cnt_q <= '0; busy_q <= 1'b0; done <= 1'b0; root <= '0;
      end else if (soft_clr) begin
         rad_q <= '0; chk_q <= '0; rem_q <= '0; cnt_q <= '0; busy_q <= 1'b0; done <= 1'b0; root <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rad_q  <= rad;
            chk_q  <= rad;
            rem_q  <= '0;
            root   <= '0;
            cnt_q  <= CNTW'(SW);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            rad_q <= rad_q << 2;
            if (sh_c >= trial_c) begin
               rem_q <= sh_c - trial_c;
               root  <= {root[SW-2:0], 1'b1};
            end else begin
               rem_q <= sh_c;
               root  <= {root[SW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNTW'(1)) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   // R4: the finished root is the floor of the square root of the loaded radicand
   a_r4_root_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (((RW+2)'(root) * (RW+2)'(root)) <= (RW+2)'(chk_q)) &&
               ((((RW+2)'(root) + 1'b1) * ((RW+2)'(root) + 1'b1)) > (RW+2)'(chk_q)));
endmodule

// File: rtl/pwr_meas_engine.sv
module pwr_meas_engine #(
   parameter int SW      = 24,
   parameter int CW      = 24,
   parameter int GF      = 22,
   parameter int ESH     = 12,
   parameter int RMS_MIN = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          start,
   input  logic          cont_mode,
   input  logic          halt,
   input  logic          conv_stb,
   input  logic [SW-1:0] v_smp,
   input  logic [SW-1:0] i_smp,
   input  logic [SW-1:0] v_off,
   input  logic [SW-1:0] i_off,
   input  logic [SW-1:0] v_gain,
   input  logic [SW-1:0] i_gain,
   input  logic [CW-1:0] cycle_cnt,
   input  logic          clr_crdy,
   input  logic          clr_drdy,
   input  logic          mask_crdy,
   input  logic          mask_drdy,
   output logic [SW-1:0] inst_v,
   output logic [SW-1:0] inst_i,
   output logic [SW-1:0] inst_p,
   output logic [SW-1:0] energy,
   output logic [SW-1:0] v_rms,
   output logic [SW-1:0] i_rms,
   output logic          rms_ok,
   output logic          crdy,
   output logic          drdy,
   output logic          irq
);
   import pme_pkg::*;

   localparam int PRW = 2 * SW;
   localparam int EW  = SW + CW;
   localparam int SQW = 2 * SW - 2 + CW;
   localparam logic signed [EW-1:0] EMAX = $signed({{(EW-SW+1){1'b0}}, {(SW-1){1'b1}}});

   generate
      if (ESH >= EW || SW < 8 || CW < 2) begin : g_bad_cfg
         $error("pwr_meas_engine: parameter set out of range");
      end
   endgenerate

   function automatic logic [SW-1:0] sat_e(input logic signed [EW-1:0] x);
      if (x > EMAX)       return SW'(EMAX);
      else if (x < -EMAX) return SW'(-EMAX);
      else                return SW'(x);
   endfunction

   run_e                  mode_q;
   logic                  active, acc_en, stg2_q, stg_go, last_hit, first_q;
   logic [CW-1:0]         n_eff, cnt_q;
   logic signed [SW-1:0]  adj [2];
   logic signed [PRW-1:0] pw_full, pw_sh;
   logic [PRW-1:0]        sq_c [2];
   logic [SQW-1:0]        sq_acc [2];
   logic [SQW-1:0]        sq_nx  [2];
   logic signed [EW-1:0]  e_acc, e_nx;
   logic [SW-1:0]         e_pend;
   logic                  ok_pend;
   logic [1:0]            dv_done, rt_done;
   logic [SQW-1:0]        quo [2];
   logic [SW-1:0]         root [2];
   logic                  pub;

   assign active = (mode_q != RUN_IDLE);
   assign acc_en = conv_stb && active;
   assign n_eff  = (cycle_cnt == '0) ? CW'(1) : cycle_cnt;
   assign stg_go = stg2_q && active;
   assign last_hit = stg_go && !start && !halt && (cnt_q >= n_eff - 1'b1);
   assign pub    = rt_done[0];

   // Per-channel correction, divide and root
   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      pme_adjust #(.SW(SW), .GW(SW), .GF(GF)) i_adj (
         .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .en(acc_en),
         .smp(ch == 0 ? v_smp : i_smp), .off(ch == 0 ? v_off : i_off),
         .gain(ch == 0 ? v_gain : i_gain), .adj(adj[ch]));

      pme_serial_div #(.DW(SQW), .VW(CW)) i_div (
         .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .start(last_hit),
         .dividend(sq_nx[ch]), .divisor(n_eff), .done(dv_done[ch]), .quo(quo[ch]));

      pme_sqrt #(.SW(SW)) i_sqrt (
         .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .start(dv_done[ch]),
         .rad(PRW'(quo[ch] << 2)), .done(rt_done[ch]), .root(root[ch]));

      always_comb begin
         sq_c[ch]  = PRW'(adj[ch]) * PRW'(adj[ch]);
         sq_nx[ch] = sq_acc[ch] + SQW'(sq_c[ch]);
      end
   end

   assign inst_v = adj[0];
   assign inst_i = adj[1];

   always_comb begin
      pw_full = PRW'(adj[0]) * PRW'(adj[1]);
      pw_sh   = pw_full >>> (SW - 1);
      e_nx    = e_acc + EW'($signed(SW'(pw_sh)));
   end

   // Run control and window accumulation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= RUN_IDLE; stg2_q <= 1'b0; first_q <= 1'b0; cnt_q <= '0;
         e_acc <= '0; sq_acc[0] <= '0; sq_acc[1] <= '0; e_pend <= '0; ok_pend <= 1'b0; inst_p <= '0;
      end else if (soft_rst) begin
         mode_q <= RUN_IDLE; stg2_q <= 1'b0; first_q <= 1'b0; cnt_q <= '0;
         e_acc <= '0; sq_acc[0] <= '0; sq_acc[1] <= '0; e_pend <= '0; ok_pend <= 1'b0; inst_p <= '0;
      end else begin
         stg2_q <= acc_en;
         if (stg_go) inst_p <= SW'(pw_sh);
         if (start || halt) begin
            mode_q  <= start ? (cont_mode ? RUN_LOOP : RUN_ONCE) : RUN_IDLE;
            first_q <= start;
            cnt_q   <= '0;
            e_acc   <= '0;
            for (int k = 0; k < 2; k++) sq_acc[k] <= '0;
         end else if (last_hit) begin
            cnt_q   <= '0;
            e_acc   <= '0;
            for (int k = 0; k < 2; k++) sq_acc[k] <= '0;
            e_pend  <= sat_e(e_nx >>> ESH);
            ok_pend <= !first_q && (n_eff > CW'(RMS_MIN));
            first_q <= 1'b0;
            if (mode_q == RUN_ONCE) mode_q <= RUN_IDLE;
         end else if (stg_go) begin
            cnt_q <= cnt_q + 1'b1;
            e_acc <= e_nx;
            for (int k = 0; k < 2; k++) sq_acc[k] <= sq_nx[k];
         end
      end
   end

   // Published results and sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         energy <= '0; v_rms <= '0; i_rms <= '0; rms_ok <= 1'b0; crdy <= 1'b0; drdy <= 1'b0;
      end else if (soft_rst) begin
         energy <= '0; v_rms <= '0; i_rms <= '0; rms_ok <= 1'b0; crdy <= 1'b0; drdy <= 1'b0;
      end else begin
         crdy <= (crdy && !clr_crdy) || stg_go;
         drdy <= (drdy && !clr_drdy) || pub;
         if (pub) begin
            energy <= e_pend;
            v_rms  <= root[0];
            i_rms  <= root[1];
            rms_ok <= ok_pend;
         end
      end
   end

   assign irq = (crdy && mask_crdy) || (drdy && mask_drdy);

   // R6: a set flag holds until its clear input
   a_r6_crdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (crdy && !clr_crdy && !soft_rst) |=> crdy);
   a_r6_drdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (drdy && !clr_drdy && !soft_rst) |=> drdy);
   // R8: an idle engine leaves the power sample untouched
   a_r8_idle_holds_power: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == RUN_IDLE && !soft_rst) |=> $stable(inst_p));
endmodule

// File: tb/test_pwr_meas_engine.sv
module test_pwr_meas_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 0, start = 0, cont_mode = 0, halt = 0, conv_stb = 0;
   logic [23:0] v_smp = 0, i_smp = 0, v_off = 0, i_off = 0;
   logic [23:0] v_gain = 24'h400000, i_gain = 24'h400000, cycle_cnt = 24'd1000;
   logic        clr_crdy = 0, clr_drdy = 0, mask_crdy = 0, mask_drdy = 0;
   logic [23:0] inst_v, inst_i, inst_p, energy, v_rms, i_rms;
   logic        rms_ok, crdy, drdy, irq;
   int          n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   pwr_meas_engine i_pwr_meas_engine (.*);

   // rows: v, i, v_off, i_off, v_gain, i_gain, exp inst_v, exp inst_i, exp inst_p
   localparam logic [23:0] VEC [6][9] = '{
      '{24'h100000, 24'h200000, 24'h000000, 24'h000000, 24'h400000, 24'h400000, 24'h100000, 24'h200000, 24'h040000},
      '{24'hF00000, 24'h200000, 24'h000000, 24'h000000, 24'h400000, 24'h400000, 24'hF00000, 24'h200000, 24'hFC0000},
      '{24'h100000, 24'h100000, 24'h010000, 24'hF00000, 24'h400000, 24'h400000, 24'h110000, 24'h000000, 24'h000000},
      '{24'h300000, 24'h400000, 24'h000000, 24'h000000, 24'h800000, 24'h200000, 24'h600000, 24'h200000, 24'h180000},
      '{24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h000000, 24'h400000, 24'h400000, 24'h7FFFFF, 24'h800001, 24'h800001},
      '{24'h000003, 24'hFFFFFD, 24'h000000, 24'h000000, 24'h200000, 24'h200000, 24'h000001, 24'hFFFFFE, 24'hFFFFFF}
   };

   task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk) sig = 1'b1;
      @(negedge clk) sig = 1'b0;
   endtask

   // strobe at a falling edge; on return the bench sits one falling edge after the strobe
   task automatic strobe(input logic [23:0] v, input logic [23:0] i);
      @(negedge clk);
      v_smp = v; i_smp = i; conv_stb = 1'b1;
      @(negedge clk) conv_stb = 1'b0;
   endtask

   task automatic wait_drdy(output bit seen);
      seen = 0;
      for (int k = 0; k < 400 && !seen; k++) begin
         @(negedge clk);
         if (drdy) seen = 1;
      end
   endtask

   initial begin
      bit seen;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 reset inst_v", inst_v, 24'h0);
      chk("R11 reset energy", energy, 24'h0);
      chk("R11 reset flags", {22'h0, crdy, drdy}, 24'h0);
      rst_n = 1'b1;
      // R8: strobes before any start are ignored
      strobe(24'h123456, 24'h111111);
      @(negedge clk);
      chk("R8 idle inst_v", inst_v, 24'h0);
      chk("R8 idle crdy", {23'h0, crdy}, 24'h0);

      // R1, R2: vector table in a long continuous window
      cont_mode = 1'b1; cycle_cnt = 24'd1000;
      pulse(start);
      for (int r = 0; r < 6; r++) begin
         v_off = VEC[r][2]; i_off = VEC[r][3]; v_gain = VEC[r][4]; i_gain = VEC[r][5];
         strobe(VEC[r][0], VEC[r][1]);
         chk($sformatf("R1 row%0d inst_v", r), inst_v, VEC[r][6]);
         chk($sformatf("R1 row%0d inst_i", r), inst_i, VEC[r][7]);
         @(negedge clk);
         chk($sformatf("R2 row%0d inst_p", r), inst_p, VEC[r][8]);
      end
      // R5: conversion flag set; R7: interrupt masking
      chk("R5 crdy after conversions", {23'h0, crdy}, 24'h1);
      chk("R7 irq masked", {23'h0, irq}, 24'h0);
      @(negedge clk) mask_crdy = 1'b1;
      @(negedge clk);
      chk("R7 irq unmasked", {23'h0, irq}, 24'h1);
      pulse(clr_crdy);
      chk("R6 crdy cleared", {23'h0, crdy}, 24'h0);
      chk("R7 irq after clear", {23'h0, irq}, 24'h0);
      mask_crdy = 1'b0;

      // R11: soft reset
      pulse(soft_rst);
      chk("R11 soft reset inst_v", inst_v, 24'h0);
      chk("R11 soft reset inst_p", inst_p, 24'h0);
      v_off = 0; i_off = 0; v_gain = 24'h400000; i_gain = 24'h400000;

      // R3, R4, R5, R10: N = 4 window
      cycle_cnt = 24'd4; cont_mode = 1'b1;
      pulse(start);
      for (int k = 0; k < 3; k++) strobe(24'h400000, 24'h400000);
      repeat (150) @(negedge clk);
      chk("R5 drdy low in open window", {23'h0, drdy}, 24'h0);
      strobe(24'h400000, 24'h400000);
      wait_drdy(seen);
      chk("R5 drdy after N=4", {23'h0, drdy}, 24'h1);
      chk("R3 energy N=4", energy, 24'h000800);
      chk("R4 v_rms N=4", v_rms, 24'h800000);
      chk("R4 i_rms N=4", i_rms, 24'h800000);
      chk("R10 rms_ok first window", {23'h0, rms_ok}, 24'h0);
      repeat (20) @(negedge clk);
      chk("R6 drdy held", {23'h0, drdy}, 24'h1);
      mask_drdy = 1'b1;
      @(negedge clk);
      chk("R7 irq from drdy", {23'h0, irq}, 24'h1);
      mask_drdy = 1'b0;

      // R9, R10: N = 11 continuous, two windows
      cycle_cnt = 24'd11;
      pulse(clr_drdy);
      pulse(start);
      for (int k = 0; k < 11; k++) strobe(24'h400000, 24'hE00000);
      wait_drdy(seen);
      chk("R3 energy N=11", energy, 24'hFFF500);
      chk("R4 i_rms N=11", i_rms, 24'h400000);
      chk("R10 rms_ok first of run", {23'h0, rms_ok}, 24'h0);
      pulse(clr_drdy);
      for (int k = 0; k < 11; k++) strobe(24'h400000, 24'hE00000);
      wait_drdy(seen);
      chk("R9 second window drdy", {23'h0, drdy}, 24'h1);
      chk("R9 second window energy", energy, 24'hFFF500);
      chk("R10 rms_ok second window", {23'h0, rms_ok}, 24'h1);

      // R9: halt stops the run
      pulse(halt);
      pulse(clr_drdy);
      pulse(clr_crdy);
      for (int k = 0; k < 11; k++) strobe(24'h100000, 24'h100000);
      repeat (300) @(negedge clk);
      chk("R9 no drdy after halt", {23'h0, drdy}, 24'h0);
      chk("R9 no crdy after halt", {23'h0, crdy}, 24'h0);
      chk("R9 inst_v frozen after halt", inst_v, 24'h400000);

      // R8, R4: single window N = 2, root floor
      cycle_cnt = 24'd2; cont_mode = 1'b0;
      pulse(start);
      strobe(24'h000003, 24'h000000);
      strobe(24'h000004, 24'h000000);
      wait_drdy(seen);
      chk("R4 v_rms floor", v_rms, 24'h000006);
      chk("R4 i_rms zero", i_rms, 24'h000000);
      chk("R3 energy zero", energy, 24'h000000);
      chk("R10 rms_ok single mode", {23'h0, rms_ok}, 24'h0);
      pulse(clr_crdy);
      strobe(24'h000005, 24'h000005);
      @(negedge clk);
      chk("R8 idle after single inst_v", inst_v, 24'h000004);
      chk("R8 idle after single crdy", {23'h0, crdy}, 24'h0);

      // R5: N = 1, each conversion closes a window
      cycle_cnt = 24'd1;
      pulse(clr_drdy);
      pulse(start);
      strobe(24'h400000, 24'h400000);
      wait_drdy(seen);
      chk("R5 N=1 drdy", {23'h0, drdy}, 24'h1);
      chk("R5 N=1 crdy", {23'h0, crdy}, 24'h1);
      chk("R3 energy N=1", energy, 24'h000200);

      // R11: soft reset clears results
      pulse(soft_rst);
      chk("R11 soft reset energy", energy, 24'h0);
      chk("R11 soft reset v_rms", v_rms, 24'h0);
      chk("R11 soft reset drdy", {23'h0, drdy}, 24'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule